// File: doc/BRIEF.md
# Three-Mode Button Command Decoder

This block sits between a button conditioning stage and a stack calculator datapath. It receives one-cycle press pulses from four buttons: two operand buttons (A and B), a step button and a clear button. It converts them into single-cycle command pulses. A small mode register decides what the operand buttons mean. In the base mode they push and pop. One step press selects the arithmetic mode, where they add and subtract. A second step press selects the extended mode, where they negate the top entry and exchange the top two entries. A third step press returns to the base mode.

Any operation issued from the arithmetic or extended mode drops the decoder back to the base mode, so every non-base command takes a fresh touch sequence. The clear button issues a clear command in every mode and returns the mode to base. A cycle in which more than one button pulses is discarded. Debouncing, edge detection and the execution of the commands belong to neighbouring blocks.

Top module: `btn_cmd_decoder`

## Requirements
- R1: While rst_ni is low and on the first cycle after it is released, mode_o is 0 and cmd_o is all zero.
- R2: In mode 0, a press of button A (press_i[0]) yields cmd_o[0] (push) and a press of button B (press_i[1]) yields cmd_o[1] (pop); the mode stays 0.
- R3: A press of the step button (press_i[2]) advances mode_o 0 to 1, 1 to 2 and 2 to 0, and issues no command.
- R4: In mode 1, button A yields cmd_o[2] (add) and button B yields cmd_o[3] (subtract); the mode returns to 0 in the same cycle as the command.
- R5: In mode 2, button A yields cmd_o[4] (negate top) and button B yields cmd_o[5] (exchange top two); the mode returns to 0 in the same cycle as the command.
- R6: A press of the clear button (press_i[3]) yields cmd_o[6] in any mode, and mode_o is 0 in the same cycle as that pulse.
- R7: A command appears on cmd_o in the cycle after its press and lasts exactly one cycle; a cycle with no press gives cmd_o of zero on the next cycle and leaves the mode unchanged.
- R8: A cycle with two or more press bits set is ignored: the next cycle has cmd_o of zero and the same mode_o.
- R9: cmd_o never has more than one bit set, and mode_o never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| press_i | input | 4 | One-cycle press pulses: bit 0 button A, bit 1 button B, bit 2 step, bit 3 clear |
| cmd_o | output | 7 | One-hot command pulse: push, pop, add, sub, negate, exchange, clear (bits 0 to 6) |
| mode_o | output | 2 | Current mode, 0 to 2 |

## Verification
Directed touch sequences walk each mode and issue both operand commands there. This separates a wrong command table from a wrong mode transition, because the mode returns to base after each command. Step presses repeated with no operand in between show the wrap from mode 2 back to 0, and the clear button pressed in every mode shows that clear ignores the mode. Pairs and full sets of simultaneous presses, including step together with clear, show that a multi-press is discarded rather than resolved by priority. A long random stream with idle gaps, single presses and multi-presses is compared cycle by cycle against a table-driven model. A mid-run reset shows the return to the idle state.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int NBTN   = 4;
  localparam int CMD_W  = 7;
  localparam int MODE_W = 2;

  localparam int BTN_A    = 0;
  localparam int BTN_B    = 1;
  localparam int BTN_STEP = 2;
  localparam int BTN_CLR  = 3;

  localparam int CMD_PUSH = 0;
  localparam int CMD_POP  = 1;
  localparam int CMD_ADD  = 2;
  localparam int CMD_SUB  = 3;
  localparam int CMD_NEG  = 4;
  localparam int CMD_XCHG = 5;
  localparam int CMD_CLR  = 6;

  typedef enum logic [MODE_W-1:0] {
    MODE_BASE  = 2'd0,
    MODE_ARITH = 2'd1,
    MODE_EXT   = 2'd2
  } mode_e;
endpackage

// File: rtl/press_qualify.sv
module press_qualify
  import cmd_dec_pkg::*;
#(
  parameter int N = NBTN
) (
  input  logic [N-1:0] press_i,
  output logic         single_o,
  output logic [N-1:0] sel_o
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CW'(press_i[i]);
  end

  assign single_o = (cnt == CW'(1));
  assign sel_o    = single_o ? press_i : '0;
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import cmd_dec_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NBTN-1:0] sel_i,
  output mode_e           mode_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (sel_i[BTN_CLR]) begin
      mode_d = MODE_BASE;
    end else if (sel_i[BTN_STEP]) begin
      unique case (mode_q)
        MODE_BASE:  mode_d = MODE_ARITH;
        MODE_ARITH: mode_d = MODE_EXT;
        default:    mode_d = MODE_BASE;
      endcase
    end else if (sel_i[BTN_A] || sel_i[BTN_B]) begin
      // any operation leaves the decoder in base mode
      mode_d = MODE_BASE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_BASE;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/cmd_map.sv
module cmd_map
  import cmd_dec_pkg::*;
(
  input  mode_e            mode_i,
  input  logic [NBTN-1:0]  sel_i,
  output logic [CMD_W-1:0] cmd_o
);
  logic [CMD_W-1:0] op_a, op_b;

  always_comb begin
    op_a = '0;
    op_b = '0;
    unique case (mode_i)
      MODE_ARITH: begin op_a[CMD_ADD] = 1'b1; op_b[CMD_SUB]  = 1'b1; end
      MODE_EXT:   begin op_a[CMD_NEG] = 1'b1; op_b[CMD_XCHG] = 1'b1; end
      default:    begin op_a[CMD_PUSH] = 1'b1; op_b[CMD_POP] = 1'b1; end
    endcase
  end

  always_comb begin
    cmd_o = '0;
    if (sel_i[BTN_CLR])    cmd_o[CMD_CLR] = 1'b1;
    else if (sel_i[BTN_A]) cmd_o = op_a;
    else if (sel_i[BTN_B]) cmd_o = op_b;
  end
endmodule

// File: rtl/btn_cmd_decoder.sv
module btn_cmd_decoder
  import cmd_dec_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NBTN-1:0]     press_i,
  output logic [CMD_W-1:0]    cmd_o,
  output logic [MODE_W-1:0]   mode_o
);
  logic             single;
  logic [NBTN-1:0]  sel;
  mode_e            mode_q;
  logic [CMD_W-1:0] cmd_d, cmd_q;

  press_qualify #(.N(NBTN)) i_qual (
    .press_i  (press_i),
    .single_o (single),
    .sel_o    (sel)
  );

  mode_fsm i_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .mode_o (mode_q)
  );

  cmd_map i_map (
    .mode_i (mode_q),
    .sel_i  (sel),
    .cmd_o  (cmd_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= '0;
    else         cmd_q <= cmd_d;
  end

  assign cmd_o  = cmd_q;
  assign mode_o = mode_q;

  logic unused_single;
  assign unused_single = single;
endmodule

// File: rtl/btn_cmd_decoder_chk.sv
module btn_cmd_decoder_chk
  import cmd_dec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NBTN-1:0]   press_i,
  input logic [CMD_W-1:0]  cmd_o,
  input logic [MODE_W-1:0] mode_o
);
  p_cmd_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_o));

  p_mode_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);

  p_multi_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(press_i) > 1) |=> (cmd_o == '0) && $stable(mode_o));

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (press_i == '0) |=> (cmd_o == '0) && $stable(mode_o));

  p_clear_base_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CMD_CLR] |-> mode_o == 2'd0);

  p_op_base_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_o[CMD_XCHG:CMD_ADD]) |-> mode_o == 2'd0);

  p_step_base_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (press_i == 4'b0100 && mode_o == 2'd0) |=> (mode_o == 2'd1) && (cmd_o == '0));

  p_push_base_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (press_i == 4'b0001 && mode_o == 2'd0) |=> cmd_o[CMD_PUSH] && mode_o == 2'd0);
endmodule

bind btn_cmd_decoder btn_cmd_decoder_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .press_i (press_i),
  .cmd_o   (cmd_o),
  .mode_o  (mode_o)
);

// File: tb/test_btn_cmd_decoder.sv
module test_btn_cmd_decoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] press_i = '0;
  logic [6:0] cmd_o;
  logic [1:0] mode_o;

  int n_run = 0, n_fail = 0;
  int m_mode = 0;
  logic [6:0] e_cmd = '0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  btn_cmd_decoder i_btn_cmd_decoder (
    .clk_i (clk_i), .rst_ni (rst_ni), .press_i (press_i),
    .cmd_o (cmd_o), .mode_o (mode_o)
  );

  // command number per [mode][operand] (0 push,1 pop,2 add,3 sub,4 neg,5 xchg)
  function automatic int op_code(int md, int which);
    int tbl [6] = '{0, 1, 2, 3, 4, 5};
    return tbl[md * 2 + which];
  endfunction

  task automatic model(logic [3:0] p);
    int ones = 0;
    for (int i = 0; i < 4; i++) ones += p[i];
    e_cmd = '0;
    if (ones != 1) return;
    if (p[3]) begin e_cmd[6] = 1; m_mode = 0; end
    else if (p[2]) m_mode = (m_mode + 1) % 3;
    else begin
      e_cmd[op_code(m_mode, p[1] ? 1 : 0)] = 1;
      m_mode = 0;
    end
  endtask

  task automatic compare(string req);
    n_run++;
    if (cmd_o !== e_cmd || mode_o !== 2'(m_mode)) begin
      n_fail++;
      $display("FAIL %s: cmd=%b mode=%0d expected cmd=%b mode=%0d",
               req, cmd_o, mode_o, e_cmd, m_mode);
    end
  endtask

  // drive press for one edge, then compare 1 ns after the edge
  task automatic step(logic [3:0] p, string req);
    press_i = p;
    model(p);
    @(posedge clk_i); #1;
    press_i = '0;
    compare(req);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #20; compare("R1 in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1; compare("R1 after release");

    step(4'b0001, "R2 push");
    step(4'b0010, "R2 pop");
    step(4'b0000, "R7 idle");
    step(4'b0100, "R3 to mode 1");
    step(4'b0000, "R7 idle holds mode");
    step(4'b0100, "R3 to mode 2");
    step(4'b0100, "R3 wrap to 0");
    step(4'b0100, "R3 to mode 1");
    step(4'b0001, "R4 add");
    step(4'b0100, "R3 to mode 1");
    step(4'b0010, "R4 sub");
    step(4'b0010, "R2 pop after sub");
    step(4'b0100, "R3 to mode 1");
    step(4'b0100, "R3 to mode 2");
    step(4'b0001, "R5 negate");
    step(4'b0100, "R3 to mode 1");
    step(4'b0100, "R3 to mode 2");
    step(4'b0010, "R5 exchange");
    step(4'b1000, "R6 clear in mode 0");
    step(4'b0100, "R3 to mode 1");
    step(4'b1000, "R6 clear in mode 1");
    step(4'b0100, "R3 to mode 1");
    step(4'b0100, "R3 to mode 2");
    step(4'b1000, "R6 clear in mode 2");
    step(4'b0100, "R3 to mode 1");
    step(4'b0011, "R8 A+B ignored");
    step(4'b1100, "R8 step+clear ignored");
    step(4'b1111, "R8 all ignored");
    step(4'b0101, "R8 A+step ignored");
    step(4'b0001, "R4 add after ignored");
    step(4'b0001, "R7 single pulse");
    step(4'b0000, "R7 pulse ends");

    for (int k = 0; k < 400; k++) begin
      logic [3:0] p;
      int r = $urandom_range(0, 9);
      if (r < 2) p = '0;
      else if (r < 8) p = 4'(1 << $urandom_range(0, 3));
      else p = 4'($urandom_range(0, 15));
      step(p, "R7 R9 random");
    end

    step(4'b0100, "R3 to mode 1");
    #2 rst_ni = 1'b0; m_mode = 0; e_cmd = '0;
    #1 compare("R1 async reset");
    @(negedge clk_i); rst_ni = 1'b1;
    step(4'b0001, "R2 push after reset");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule